// File: doc/BRIEF.md
# Toggle-write memory controller

This block sequences access to a word-organised memory whose cells cannot be set to a chosen value. A write command can only reverse the state of a bit. A cycle starts on a qualified rising edge of an asynchronous chip-select strobe. On that edge the block captures the address and the write-enable, then runs either a read or a write. A write reads the stored word, XORs it with the incoming data to find the bits that differ, and flips only those bits. The storage is a behavioural array of raw words held inside the block.

The strobe and the write-start gate are brought into the clock domain through synchronizers. Strobe pulses shorter than a set number of sampled clock cycles are discarded as glitches. A write may be held off by keeping the write-start gate low, which lets the host choose the moment the cells change. Two active-high write-allow inputs guard the lower and upper halves of the address space, so that either half can be made read-only. The data path is split into input, output and output-enable, ready for a tri-state pad. The output is enabled only during the read phase and only while the output-enable input is high. The default depth is 2^11 words; setting `ADDR_W` to 16 gives the full 65,536-word space. The control pins are plain levels with no handshake: `busy` tells the host when a new strobe edge will be accepted.

Top module: `tw_mem_ctrl`

## Requirements
- R1: After reset `busy` is low and `dq_oe` is low.
- R2: A chip-select pulse seen high for fewer than `GLITCH_CYC` (default 2) consecutive synchronized samples starts no cycle and changes no stored word.
- R3: A chip-select rising edge that stays high for `GLITCH_CYC` samples captures `addr` and `we` and starts a cycle. `busy` rises and stays high until the cycle ends.
- R4: With `we` captured low the cycle is a read, and the addressed word appears on `dq_o` while `dq_oe` is high. `oe` is not captured: raising it after the cycle has started still enables the output.
- R5: With `we` captured high the block reads the addressed word and flips only the bits where it differs from `dq_i`. A later read returns exactly `dq_i`, and rewriting the same value leaves the word unchanged.
- R6: A write whose gate `wgate` is low waits with `busy` high and no stored change until `wgate` goes high. The write then proceeds.
- R7: While `wr_allow_lo` is low, writes to addresses with the top address bit 0 leave the stored word unchanged.
- R8: While `wr_allow_hi` is low, writes to addresses with the top address bit 1 leave the stored word unchanged. Writes to the other half are not affected.
- R9: A chip-select edge that arrives while `busy` is high is ignored. It changes neither the captured address nor any stored word, and it starts no cycle after the current one ends.
- R10: A read keeps `busy` high for exactly `RD_CYC` (default 6) cycles. A write ends within `WR_HOLD`+5 (default 9) cycles of `wgate` going high.
- R11: `dq_oe` is low whenever `oe` is low, whenever no read phase is active, and throughout every write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip-select strobe, asynchronous; a rising edge starts a cycle |
| addr | input | ADDR_W | Word address, captured on the strobe edge |
| we | input | 1 | Write-enable, captured on the strobe edge |
| wgate | input | 1 | Write-start gate, asynchronous; a write waits while it is low |
| wr_allow_lo | input | 1 | High allows writes to the lower address half |
| wr_allow_hi | input | 1 | High allows writes to the upper address half |
| oe | input | 1 | Output enable, not captured |
| dq_i | input | DATA_W | Write data from the bus |
| dq_o | output | DATA_W | Read data to the bus |
| dq_oe | output | 1 | Drive enable for the bus pad |
| busy | output | 1 | High for the length of each cycle |

## Verification
The toggle-write path is tried against several kinds of stored word. A write onto a fresh word shows that the data lands. A write that differs from the stored word in a single bit shows that the compare picks out exactly the right position. A rewrite of identical data shows that an all-zero difference leaves the word intact. The strobe is driven with a one-sample pulse, a qualified pulse, and a pulse during a cycle that is already running, which separates glitch rejection from busy-time rejection. Writes are issued with the gate already high and with the gate held low for many cycles. They are also issued with each half's write-allow low in turn, which shows the two halves are protected independently. Reads are done with `oe` high at the strobe and with `oe` raised late, which shows that output-enable acts live and is not latched.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WAIT,
    ST_CMP,
    ST_HOLD
  } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tw_strobe_qual.sv
// Qualifies a synchronized strobe: needs a low-to-high transition seen while
// idle and GLITCH_CYC consecutive high samples. GLITCH_CYC must be >= 2.
module tw_strobe_qual #(
  parameter int ADDR_W     = 11,
  parameter int GLITCH_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              idle,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              start,
  output logic [ADDR_W-1:0] addr_cap,
  output logic              we_cap
);
  localparam int GCW = $clog2(GLITCH_CYC + 1);

  logic           armed;
  logic [GCW-1:0] hi_cnt;
  logic           counting;

  assign counting = idle && armed && cs_s;
  assign start    = counting && (hi_cnt == GCW'(GLITCH_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      hi_cnt   <= '0;
      addr_cap <= '0;
      we_cap   <= 1'b0;
    end else begin
      if (!cs_s)                armed <= 1'b1;
      else if (start || !idle)  armed <= 1'b0;

      if (!counting || start)   hi_cnt <= '0;
      else                      hi_cnt <= hi_cnt + GCW'(1);

      if (counting && hi_cnt == '0) begin
        addr_cap <= addr;
        we_cap   <= we;
      end
    end
  end
endmodule

// File: rtl/tw_toggle_array.sv
// Behavioural storage whose only update is a bitwise flip under a mask.
module tw_toggle_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flip_en,
  input  logic [ADDR_W-1:0] flip_addr,
  input  logic [DATA_W-1:0] flip_mask
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (rd_en)   rd_data <= cells[rd_addr];
    if (flip_en) cells[flip_addr] <= cells[flip_addr] ^ flip_mask;
  end
endmodule

// File: rtl/tw_mem_ctrl.sv
module tw_mem_ctrl
  import tw_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 16,
  parameter int GLITCH_CYC  = 2,
  parameter int SYNC_STAGES = 2,
  parameter int RD_CYC      = 6,
  parameter int WR_HOLD     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic              wgate,
  input  logic              wr_allow_lo,
  input  logic              wr_allow_hi,
  input  logic              oe,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic              busy
);
  localparam int CNT_MAX = (RD_CYC > WR_HOLD) ? RD_CYC : WR_HOLD;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  tw_state_e         state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              cs_s, gate_s;
  logic              start, we_cap;
  logic [ADDR_W-1:0] addr_cap;
  logic              rd_en, flip_en, din_ld, allow;
  logic [DATA_W-1:0] rd_data, din_q, flip_mask;

  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs), .q(cs_s));

  tw_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_gate_sync (
    .clk(clk), .rst_n(rst_n), .d(wgate), .q(gate_s));

  tw_strobe_qual #(.ADDR_W(ADDR_W), .GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .idle(state == ST_IDLE),
    .addr(addr), .we(we), .start(start), .addr_cap(addr_cap), .we_cap(we_cap));

  tw_toggle_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rd_en(rd_en), .rd_addr(addr_cap), .rd_data(rd_data),
    .flip_en(flip_en), .flip_addr(addr_cap), .flip_mask(flip_mask));

  assign flip_mask = rd_data ^ din_q;
  assign allow     = addr_cap[ADDR_W-1] ? wr_allow_hi : wr_allow_lo;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    rd_en   = 1'b0;
    flip_en = 1'b0;
    din_ld  = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        cnt_n = '0;
        if (we_cap) state_n = ST_WAIT;
        else begin
          state_n = ST_READ;
          rd_en   = 1'b1;
        end
      end
      ST_READ: begin
        if (cnt == CNT_W'(RD_CYC - 1)) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else cnt_n = cnt + CNT_W'(1);
      end
      ST_WAIT: if (gate_s) begin
        rd_en   = 1'b1;
        din_ld  = 1'b1;
        state_n = ST_CMP;
      end
      ST_CMP: begin
        flip_en = allow && (flip_mask != '0);
        state_n = ST_HOLD;
        cnt_n   = '0;
      end
      ST_HOLD: begin
        if (cnt == CNT_W'(WR_HOLD - 1)) begin
          state_n = ST_IDLE;
          cnt_n   = '0;
        end else cnt_n = cnt + CNT_W'(1);
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      din_q <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      if (din_ld) din_q <= dq_i;
    end
  end

  assign dq_o  = rd_data;
  assign dq_oe = (state == ST_READ) && oe;
  assign busy  = (state != ST_IDLE);
endmodule

// File: rtl/tw_mem_ctrl_chk.sv
module tw_mem_ctrl_chk #(
  parameter int ADDR_W = 11,
  parameter int RD_CYC = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_s,
  input logic              gate_s,
  input logic              busy,
  input logic              oe,
  input logic              we_cap,
  input logic [ADDR_W-1:0] addr_cap,
  input logic              dq_oe,
  input logic              flip_en,
  input logic              wr_allow_lo,
  input logic              wr_allow_hi
);
  localparam int RW = $clog2(RD_CYC + 2);
  logic [RW-1:0] rd_run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                rd_run <= '0;
    else if (busy && !we_cap)  rd_run <= rd_run + RW'(1);
    else                       rd_run <= '0;

  p_glitch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_s) && $past(cs_s, 2));

  p_cap_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(addr_cap) && $stable(we_cap));

  p_bus_read_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe && busy && !we_cap);

  p_gate_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flip_en |-> $past(gate_s) && busy && we_cap);

  p_allow_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flip_en && !addr_cap[ADDR_W-1] |-> wr_allow_lo);

  p_allow_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flip_en && addr_cap[ADDR_W-1] |-> wr_allow_hi);

  p_read_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !we_cap |-> rd_run < RW'(RD_CYC));
endmodule

bind tw_mem_ctrl tw_mem_ctrl_chk #(.ADDR_W(ADDR_W), .RD_CYC(RD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .gate_s(gate_s), .busy(busy),
  .oe(oe), .we_cap(we_cap), .addr_cap(addr_cap), .dq_oe(dq_oe),
  .flip_en(flip_en), .wr_allow_lo(wr_allow_lo), .wr_allow_hi(wr_allow_hi));

// File: tb/sim_tw_mem_ctrl.sv
module sim_tw_mem_ctrl;
  localparam int AW = 11, DW = 16, RD_CYC = 6, WR_HOLD = 4;
  localparam int WR_LIMIT = WR_HOLD + 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 0, we = 0, wgate = 0, oe = 0;
  logic wr_allow_lo = 1, wr_allow_hi = 1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_i = '0, dq_o;
  logic dq_oe, busy;

  int checks = 0, fails = 0;
  bit in_write = 0, prev_oe = 0;
  logic [DW-1:0] exp_q [$];

  always #2 clk = ~clk;

  tw_mem_ctrl #(.ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD_CYC), .WR_HOLD(WR_HOLD)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .addr(addr), .we(we), .wgate(wgate),
    .wr_allow_lo(wr_allow_lo), .wr_allow_hi(wr_allow_hi), .oe(oe),
    .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic pulse_cs(input int n);
    cs = 1'b1;
    repeat (n) tick();
    cs = 1'b0;
  endtask

  task automatic wait_busy();
    for (int i = 0; i < 20 && !busy; i++) tick();
  endtask

  // Scoreboard monitor: pops one expected word at each rising dq_oe.
  always @(negedge clk) begin
    if (dq_oe && !prev_oe) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected drive", int'(dq_o), 0);
      else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        chk(dq_o == e, "R4/R5 read data", int'(dq_o), int'(e));
      end
    end
    if (in_write && dq_oe) chk(1'b0, "R11 drive during write", 1, 0);
    prev_oe = dq_oe;
  end

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] e, input bit len_chk);
    int n = 0;
    addr = a; we = 1'b0; oe = 1'b1;
    exp_q.push_back(e);
    pulse_cs(3);
    wait_busy();
    while (busy && n < 50) begin n++; tick(); end
    if (len_chk) chk(n == RD_CYC, "R10 read busy length", n, RD_CYC);
    oe = 1'b0;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input int delay);
    int n = 0;
    bit held = 1;
    addr = a; we = 1'b1; dq_i = d; in_write = 1; oe = 1'b1;
    wgate = (delay == 0);
    pulse_cs(3);
    wait_busy();
    if (delay > 0) begin
      repeat (delay) begin tick(); if (!busy) held = 0; end
      chk(held, "R6 busy held while gate low", int'(held), 1);
      wgate = 1'b1;
      while (busy && n < 50) begin n++; tick(); end
      chk(n <= WR_LIMIT, "R10 write end after gate", n, WR_LIMIT);
    end else begin
      while (busy && n < 50) begin n++; tick(); end
    end
    wgate = 1'b0; we = 1'b0; in_write = 0; oe = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    bit quiet;
    repeat (3) tick();
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    chk(dq_oe == 1'b0, "R1 dq_oe after reset", int'(dq_oe), 0);
    rst_n = 1'b1;
    repeat (3) tick();

    // R3/R5 fresh write and single-bit change, identical rewrite
    do_write(11'h010, 16'hA5A5, 0);
    do_read(11'h010, 16'hA5A5, 1);
    do_write(11'h010, 16'hA5A4, 0);
    do_read(11'h010, 16'hA5A4, 0);
    do_write(11'h010, 16'hA5A4, 0);
    do_read(11'h010, 16'hA5A4, 0);
    do_write(11'h450, 16'h1234, 0);
    do_read(11'h450, 16'h1234, 1);

    // R2 glitch: one-sample strobe with a write set up
    addr = 11'h010; we = 1'b1; dq_i = 16'hFFFF; wgate = 1'b1;
    pulse_cs(1);
    quiet = 1;
    repeat (8) begin tick(); if (busy) quiet = 0; end
    chk(quiet, "R2 glitch starts no cycle", int'(!quiet), 0);
    wgate = 1'b0; we = 1'b0;
    do_read(11'h010, 16'hA5A4, 0);

    // R6 delayed write
    do_write(11'h020, 16'h5555, 10);
    do_read(11'h020, 16'h5555, 0);

    // R7 / R8 region protection
    wr_allow_lo = 1'b0;
    do_write(11'h010, 16'h0000, 0);
    do_read(11'h010, 16'hA5A4, 0);     // R7 blocked
    do_write(11'h450, 16'h4321, 0);
    do_read(11'h450, 16'h4321, 0);     // R8 upper half still open
    wr_allow_lo = 1'b1; wr_allow_hi = 1'b0;
    do_write(11'h450, 16'h0000, 0);
    do_read(11'h450, 16'h4321, 0);     // R8 blocked
    do_write(11'h020, 16'h7777, 0);
    do_read(11'h020, 16'h7777, 0);     // R7 lower half open
    wr_allow_hi = 1'b1;

    // R9 strobe edge during a busy write is ignored
    addr = 11'h030; we = 1'b1; dq_i = 16'hAAAA; wgate = 1'b0; in_write = 1; oe = 1'b1;
    pulse_cs(3);
    wait_busy();
    repeat (3) tick();
    addr = 11'h020; we = 1'b0; dq_i = 16'h0F0F;
    pulse_cs(3);
    repeat (3) tick();
    addr = 11'h030; we = 1'b1; dq_i = 16'hAAAA;
    wgate = 1'b1;
    for (int i = 0; i < 50 && busy; i++) tick();
    wgate = 1'b0; we = 1'b0; in_write = 0; oe = 1'b0;
    quiet = 1;
    repeat (8) begin tick(); if (busy) quiet = 0; end
    chk(quiet, "R9 no cycle after ignored edge", int'(!quiet), 0);
    do_read(11'h030, 16'hAAAA, 0);
    do_read(11'h020, 16'h7777, 0);

    // R4/R11 oe low at strobe, raised late
    addr = 11'h450; we = 1'b0; oe = 1'b0;
    exp_q.push_back(16'h4321);
    pulse_cs(3);
    wait_busy();
    tick();
    chk(dq_oe == 1'b0, "R11 no drive with oe low", int'(dq_oe), 0);
    oe = 1'b1;
    tick();
    chk(dq_oe == 1'b1, "R4 late oe enables output", int'(dq_oe), 1);
    for (int i = 0; i < 50 && busy; i++) tick();
    chk(dq_oe == 1'b0, "R11 no drive after read", int'(dq_oe), 0);
    oe = 1'b0;
    chk(exp_q.size() == 0, "R4 all reads observed", exp_q.size(), 0);

    repeat (4) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule